// File: doc/BRIEF.md
# Channel-to-Ethernet Frame Builder

This block sits on the return path of a link test setup. A receive-side parser delivers twelve channel words together, qualified by one strobe, plus a 20-byte signature that the test equipment placed in the frame it first sent. The builder joins these into one Ethernet II frame and streams it out over a 64-bit AXI4-Stream master toward a 10G MAC running at 156.25 MHz. The MAC appends the 4-byte FCS, so the 98 bytes sent here end at the last signature byte.

The frame starts with a 14-byte header: destination address, then source address, then type. Configuration inputs supply these three fields. An 84-byte payload follows: 60 bytes of channel data (five bytes per channel, channel 0 first), four zero bytes, and the 20-byte signature, copied exactly. The 98 bytes go out lowest lane first in 13 beats. Because the header is 14 bytes long, the channel data does not line up with beat boundaries. The block holds a full copy of the frame, so the final beat and backpressure need no special cases.

Top module: `fb_frame_builder`

## Requirements
- R1: `in_ready` is high only while no frame is in flight. A channel set is captured in the cycle where `in_valid` and `in_ready` are both high, and `m_tvalid` rises one cycle later. `in_ready` stays low until the final beat is accepted. `in_valid` raised while `in_ready` is low is ignored, and no frame is produced without an accepted channel set.
- R2: Frame bytes 0 to 5 carry `cfg_dst` and bytes 6 to 11 carry `cfg_src`, each most significant byte first. Frame byte 0 is `cfg_dst[47:40]`. Bytes 12 and 13 carry `cfg_type[15:8]` and then `cfg_type[7:0]`.
- R3: Channel c is `in_chan[40c+39:40c]`. It occupies frame bytes 14+5c to 18+5c, most significant byte first.
- R4: Frame bytes 74 to 77 are zero.
- R5: Frame bytes 78 to 97 are `in_sig`, starting with `in_sig[159:152]`, with no byte altered.
- R6: A frame is exactly 13 accepted beats. Beat b lane l (`m_tdata[8l+7:8l]`) holds frame byte 8b+l. `m_tkeep` is 8'hFF on beats 0 to 11 and 8'h03 on beat 12. `m_tlast` is high only on beat 12. Lanes 2 to 7 of beat 12 are zero. `m_tvalid` is low in the cycle after the last beat is accepted.
- R7: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tkeep` and `m_tlast` hold their values in the next cycle.
- R8: Header fields are sampled in the capture cycle. Changing `cfg_dst`, `cfg_src` or `cfg_type` later has no effect on the frame in flight.
- R9: While `rst` is high and right after it is released, `m_tvalid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dst | input | 48 | Destination address |
| cfg_src | input | 48 | Source address |
| cfg_type | input | 16 | Type field |
| in_valid | input | 1 | Channel set strobe |
| in_ready | output | 1 | Builder idle, channel set can be taken |
| in_chan | input | 480 | Twelve 40-bit channel words, channel 0 in the low bits |
| in_sig | input | 160 | Captured signature |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream beat accepted by the MAC |
| m_tdata | output | 64 | Stream data, lane 0 in the low byte |
| m_tkeep | output | 8 | Byte enables per lane |
| m_tlast | output | 1 | Final beat of the frame |

## Verification
The assertions check on every cycle that `in_ready` and `m_tvalid` are never high together, that a frame starts only after a capture, and that stalled beats hold still. They also check that `m_tkeep` is full on body beats and 8'h03 on the last beat, that `m_tlast` falls on the thirteenth accepted beat, and that the stream goes quiet after it. Byte placement cannot be checked that way: header order, channel misalignment across beats, the zero gap and the exact signature copy are shown only by the scoreboard, which compares every lane with a frame built from the requirements. The same holds for sampling the configuration at capture and for ignoring a strobe sent while busy. The scoreboard covers these under free-flowing and random backpressure.

// File: rtl/fb_pkg.sv
package fb_pkg;

    localparam int MAC_BYTES  = 6;
    localparam int TYPE_BYTES = 2;
    localparam int HDR_BYTES  = 2 * MAC_BYTES + TYPE_BYTES;

    typedef struct packed {
        logic [8*MAC_BYTES-1:0]  dst;
        logic [8*MAC_BYTES-1:0]  src;
        logic [8*TYPE_BYTES-1:0] etype;
    } fb_hdr_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } fb_state_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int tail_lanes(input int total, input int lanes);
        int r;
        r = total % lanes;
        return (r == 0) ? lanes : r;
    endfunction

endpackage

// File: rtl/fb_frame_map.sv
module fb_frame_map
    import fb_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int CH_BYTES  = 5,
    parameter int GAP_BYTES = 4,
    parameter int SIG_BYTES = 20,
    parameter int IMG_BYTES = 104
) (
    input  fb_hdr_t                        hdr,
    input  logic [8*NUM_CH*CH_BYTES-1:0]   chan,
    input  logic [8*SIG_BYTES-1:0]         sig,
    output logic [8*IMG_BYTES-1:0]         image
);
    localparam int CH_OFF      = HDR_BYTES;
    localparam int GAP_OFF     = CH_OFF + NUM_CH * CH_BYTES;
    localparam int SIG_OFF     = GAP_OFF + GAP_BYTES;
    localparam int FRAME_BYTES = SIG_OFF + SIG_BYTES;

    // Addresses, most significant byte on the wire first
    for (genvar i = 0; i < MAC_BYTES; i++) begin : g_mac
        assign image[8*i +: 8]               = hdr.dst[8*(MAC_BYTES-1-i) +: 8];
        assign image[8*(MAC_BYTES+i) +: 8]   = hdr.src[8*(MAC_BYTES-1-i) +: 8];
    end

    for (genvar t = 0; t < TYPE_BYTES; t++) begin : g_type
        assign image[8*(2*MAC_BYTES+t) +: 8] = hdr.etype[8*(TYPE_BYTES-1-t) +: 8];
    end

    // Channel words, each most significant byte first
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar j = 0; j < CH_BYTES; j++) begin : g_byte
            assign image[8*(CH_OFF + c*CH_BYTES + j) +: 8] =
                chan[8*(c*CH_BYTES + CH_BYTES-1-j) +: 8];
        end
    end

    for (genvar g = 0; g < GAP_BYTES; g++) begin : g_gap
        assign image[8*(GAP_OFF+g) +: 8] = 8'h00;
    end

    for (genvar s = 0; s < SIG_BYTES; s++) begin : g_sig
        assign image[8*(SIG_OFF+s) +: 8] = sig[8*(SIG_BYTES-1-s) +: 8];
    end

    // Lanes past the end of the frame in the final beat
    for (genvar k = FRAME_BYTES; k < IMG_BYTES; k++) begin : g_tail
        assign image[8*k +: 8] = 8'h00;
    end

endmodule

// File: rtl/fb_frame_store.sv
module fb_frame_store #(
    parameter int W = 832
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/fb_beat_ctrl.sv
module fb_beat_ctrl
    import fb_pkg::*;
#(
    parameter int NUM_BEATS  = 13,
    parameter int LANES      = 8,
    parameter int LAST_LANES = 2,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tready,
    output logic             idle,
    output logic             tvalid,
    output logic             tlast,
    output logic [LANES-1:0] tkeep,
    output logic [IDX_W-1:0] beat
);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_BEATS - 1);
    localparam logic [LANES-1:0] LAST_MASK = LANES'((64'd1 << LAST_LANES) - 64'd1);

    fb_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SEND;
                        beat  <= '0;
                    end
                end
                ST_SEND: begin
                    if (tready) begin
                        if (beat == LAST_IDX) begin
                            state <= ST_IDLE;
                            beat  <= '0;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle   = (state == ST_IDLE);
        tvalid = (state == ST_SEND);
        tlast  = tvalid && (beat == LAST_IDX);
        if (!tvalid)    tkeep = '0;
        else if (tlast) tkeep = LAST_MASK;
        else            tkeep = '1;
    end
endmodule

// File: rtl/fb_lane_select.sv
module fb_lane_select #(
    parameter int LANES     = 8,
    parameter int NUM_BEATS = 13,
    parameter int IDX_W     = 4
) (
    input  logic [8*LANES*NUM_BEATS-1:0] image,
    input  logic [IDX_W-1:0]             beat,
    input  logic                         valid,
    output logic [8*LANES-1:0]           tdata
);
    localparam int DATA_W = 8 * LANES;

    logic [DATA_W-1:0] beat_words [NUM_BEATS];

    for (genvar b = 0; b < NUM_BEATS; b++) begin : g_beat
        assign beat_words[b] = image[b*DATA_W +: DATA_W];
    end

    always_comb begin
        tdata = '0;
        for (int b = 0; b < NUM_BEATS; b++) begin
            if (valid && (int'(beat) == b)) tdata = beat_words[b];
        end
    end
endmodule

// File: rtl/fb_frame_builder.sv
module fb_frame_builder
    import fb_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int NUM_CH    = 12,
    parameter int CH_BYTES  = 5,
    parameter int GAP_BYTES = 4,
    parameter int SIG_BYTES = 20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [8*MAC_BYTES-1:0]        cfg_dst,
    input  logic [8*MAC_BYTES-1:0]        cfg_src,
    input  logic [8*TYPE_BYTES-1:0]       cfg_type,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [8*NUM_CH*CH_BYTES-1:0]  in_chan,
    input  logic [8*SIG_BYTES-1:0]        in_sig,
    output logic                          m_tvalid,
    input  logic                          m_tready,
    output logic [8*LANES-1:0]            m_tdata,
    output logic [LANES-1:0]              m_tkeep,
    output logic                          m_tlast
);
    localparam int FRAME_BYTES = HDR_BYTES + NUM_CH*CH_BYTES + GAP_BYTES + SIG_BYTES;
    localparam int NUM_BEATS   = ceil_div(FRAME_BYTES, LANES);
    localparam int LAST_LANES  = tail_lanes(FRAME_BYTES, LANES);
    localparam int IMG_BYTES   = NUM_BEATS * LANES;
    localparam int IDX_W       = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1;

    fb_hdr_t                 hdr;
    logic                    accept;
    logic [8*IMG_BYTES-1:0]  image_next;
    logic [8*IMG_BYTES-1:0]  image_q;
    logic [IDX_W-1:0]        beat;
    logic                    idle;

    assign hdr    = '{dst: cfg_dst, src: cfg_src, etype: cfg_type};
    assign accept = in_valid && in_ready;
    assign in_ready = idle;

    fb_frame_map #(
        .NUM_CH(NUM_CH), .CH_BYTES(CH_BYTES), .GAP_BYTES(GAP_BYTES),
        .SIG_BYTES(SIG_BYTES), .IMG_BYTES(IMG_BYTES)
    ) map_i (
        .hdr(hdr), .chan(in_chan), .sig(in_sig), .image(image_next)
    );

    fb_frame_store #(.W(8*IMG_BYTES)) store_i (
        .clk(clk), .rst(rst), .load(accept), .d(image_next), .q(image_q)
    );

    fb_beat_ctrl #(
        .NUM_BEATS(NUM_BEATS), .LANES(LANES), .LAST_LANES(LAST_LANES), .IDX_W(IDX_W)
    ) ctrl_i (
        .clk(clk), .rst(rst), .start(accept), .tready(m_tready),
        .idle(idle), .tvalid(m_tvalid), .tlast(m_tlast), .tkeep(m_tkeep), .beat(beat)
    );

    fb_lane_select #(
        .LANES(LANES), .NUM_BEATS(NUM_BEATS), .IDX_W(IDX_W)
    ) sel_i (
        .image(image_q), .beat(beat), .valid(m_tvalid), .tdata(m_tdata)
    );

endmodule

// File: rtl/fb_frame_builder_chk.sv
module fb_frame_builder_chk #(
    parameter int LANES      = 8,
    parameter int NUM_BEATS  = 13,
    parameter int LAST_LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             m_tvalid,
    input logic             m_tready,
    input logic [8*LANES-1:0] m_tdata,
    input logic [LANES-1:0] m_tkeep,
    input logic             m_tlast
);
    localparam int CNT_W = $clog2(NUM_BEATS + 1);
    localparam logic [LANES-1:0] LAST_MASK = LANES'((64'd1 << LAST_LANES) - 64'd1);

    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (m_tvalid && m_tready) begin
            seen <= m_tlast ? '0 : seen + 1'b1;
        end
    end

    // R1: never ready for a new set while a beat is offered
    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> !in_ready);

    // R1: a frame only begins after a capture handshake
    a_r1_start_after_capture: assert property (@(posedge clk) disable iff (rst)
        $rose(m_tvalid) |-> $past(in_valid && in_ready));

    // R6: body beats carry all lanes
    a_r6_keep_body: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tlast) |-> (m_tkeep == {LANES{1'b1}}));

    // R6: final beat carries the tail lanes only
    a_r6_keep_last: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tlast) |-> (m_tkeep == LAST_MASK));

    // R6: tlast sits on the last beat of the count
    a_r6_frame_len: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tlast) |-> (seen == CNT_W'(NUM_BEATS - 1)));

    // R6: stream idles after the final beat
    a_r6_gap_after_last: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);

    // R7: stalled beat is held
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tkeep) && $stable(m_tlast)));

endmodule

bind fb_frame_builder fb_frame_builder_chk #(
    .LANES(LANES), .NUM_BEATS(NUM_BEATS), .LAST_LANES(LAST_LANES)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast)
);

// File: tb/fb_frame_builder_tb_top.sv
module fb_frame_builder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;
    localparam int NBEATS     = 13;

    logic         clk = 1'b0;
    logic         rst;
    logic [47:0]  cfg_dst, cfg_src;
    logic [15:0]  cfg_type;
    logic         in_valid;
    logic         in_ready;
    logic [479:0] in_chan;
    logic [159:0] in_sig;
    logic         m_tvalid;
    logic         m_tready;
    logic [63:0]  m_tdata;
    logic [7:0]   m_tkeep;
    logic         m_tlast;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [63:0] q_data[$];
    logic [7:0]  q_keep[$];
    logic        q_last[$];
    int          q_beat[$];
    string       q_note[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_frame_builder dut_i (
        .clk(clk), .rst(rst), .cfg_dst(cfg_dst), .cfg_src(cfg_src), .cfg_type(cfg_type),
        .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan), .in_sig(in_sig),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string region_tag(input int idx);
        if (idx < 14) return "R2";
        if (idx < 74) return "R3";
        if (idx < 78) return "R4";
        if (idx < 98) return "R5";
        return "R6";
    endfunction

    function automatic logic [7:0] frame_byte(input int i, input logic [47:0] d,
        input logic [47:0] s, input logic [15:0] ty, input logic [479:0] ch,
        input logic [159:0] sg);
        int c, j;
        if (i < 6)  return 8'(d >> (8*(5-i)));
        if (i < 12) return 8'(s >> (8*(11-i)));
        if (i < 14) return 8'(ty >> (8*(13-i)));
        if (i < 74) begin
            c = (i-14) / 5;
            j = (i-14) % 5;
            return 8'(ch >> (8*(c*5 + 4 - j)));
        end
        if (i < 78) return 8'h00;
        if (i < 98) return 8'(sg >> (8*(97-i)));
        return 8'h00;
    endfunction

    task automatic send_frame(input logic [479:0] ch, input logic [159:0] sg,
                              input string note);
        logic [63:0] w;
        do @(negedge clk); while (!in_ready);
        for (int b = 0; b < NBEATS; b++) begin
            w = '0;
            for (int l = 0; l < 8; l++)
                w[8*l +: 8] = frame_byte(8*b + l, cfg_dst, cfg_src, cfg_type, ch, sg);
            q_data.push_back(w);
            q_keep.push_back((b == NBEATS-1) ? 8'h03 : 8'hFF);
            q_last.push_back(b == NBEATS-1);
            q_beat.push_back(b);
            q_note.push_back(note);
        end
        in_chan  = ch;
        in_sig   = sg;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Monitor: drives tready, pops expected beats, checks hold under stall
    initial begin
        logic        prev_stall;
        logic [63:0] prev_d;
        logic [7:0]  prev_k;
        logic        prev_l;
        logic [63:0] ed;
        int          eb;
        int          bad;
        string       nt;
        prev_stall = 0;
        prev_d = '0; prev_k = '0; prev_l = 0;
        m_tready = 1'b1;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (bp_mode)
                1:       m_tready = lfsr[0] | lfsr[5];
                2:       m_tready = lfsr[0] & lfsr[5];
                default: m_tready = 1'b1;
            endcase
            #1;
            if (rst) begin
                prev_stall = 0;
            end else begin
                if (prev_stall) begin
                    check(m_tvalid === 1'b1, "R7", "tvalid held", 64'(m_tvalid), 64'd1);
                    check(m_tdata === prev_d && m_tkeep === prev_k && m_tlast === prev_l,
                          "R7", "beat held", m_tdata, prev_d);
                end
                if (m_tvalid && m_tready) begin
                    if (q_data.size() == 0) begin
                        check(0, "R1", "beat with no accepted set", m_tdata, 64'd0);
                    end else begin
                        ed = q_data.pop_front();
                        eb = q_beat.pop_front();
                        nt = q_note.pop_front();
                        bad = -1;
                        for (int l = 7; l >= 0; l--)
                            if (m_tdata[8*l +: 8] !== ed[8*l +: 8]) bad = l;
                        check(bad < 0, (bad < 0) ? "R6" : region_tag(8*eb + bad),
                              $sformatf("%s beat %0d data", nt, eb), m_tdata, ed);
                        check(m_tkeep === q_keep.pop_front(), "R6",
                              $sformatf("%s beat %0d tkeep", nt, eb), 64'(m_tkeep),
                              (eb == NBEATS-1) ? 64'h03 : 64'hFF);
                        check(m_tlast === q_last.pop_front(), "R6",
                              $sformatf("%s beat %0d tlast", nt, eb), 64'(m_tlast),
                              64'(eb == NBEATS-1));
                    end
                end
                prev_stall = m_tvalid && !m_tready;
                prev_d = m_tdata; prev_k = m_tkeep; prev_l = m_tlast;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    function automatic logic [479:0] ramp(input logic [7:0] seed);
        logic [479:0] v;
        for (int k = 0; k < 60; k++) v[8*k +: 8] = seed + 8'(k);
        return v;
    endfunction

    function automatic logic [159:0] sig_pat(input logic [7:0] seed);
        logic [159:0] v;
        for (int k = 0; k < 20; k++) v[8*k +: 8] = seed ^ 8'(k * 13);
        return v;
    endfunction

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_chan  = '0;
        in_sig   = '0;
        cfg_dst  = 48'h0A1B2C3D4E5F;
        cfg_src  = 48'h112233445566;
        cfg_type = 16'h88B5;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(m_tvalid === 1'b0, "R9", "tvalid in reset", 64'(m_tvalid), 64'd0);
        check(in_ready === 1'b1, "R9", "in_ready in reset", 64'(in_ready), 64'd1);
        in_valid = 1'b1;                 // strobe during reset is not captured
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(m_tvalid === 1'b0, "R9", "tvalid after reset", 64'(m_tvalid), 64'd0);
        check(in_ready === 1'b1, "R9", "in_ready after reset", 64'(in_ready), 64'd1);

        // R2 R3 R5 R6: ramp data, free flow
        bp_mode = 0;
        send_frame(ramp(8'h00), sig_pat(8'h5A), "ramp");
        check(m_tvalid === 1'b1, "R1", "tvalid one cycle after capture", 64'(m_tvalid), 64'd1);
        check(in_ready === 1'b0, "R1", "in_ready low in frame", 64'(in_ready), 64'd0);

        // R7: random backpressure, distinct patterns
        bp_mode = 1;
        send_frame({480{1'b1}}, {80{2'b10}}, "ones");
        send_frame(ramp(8'h80), sig_pat(8'hC3), "ramp2");
        bp_mode = 2;
        send_frame({96{5'b10110}}, sig_pat(8'h0F), "stripe");

        // R4 R5 boundary: all-zero channels, all-ones signature
        bp_mode = 0;
        send_frame('0, {160{1'b1}}, "zeros");

        // R1: strobe while busy is ignored
        send_frame(ramp(8'h40), sig_pat(8'h99), "busy");
        check(in_ready === 1'b0, "R1", "in_ready while sending", 64'(in_ready), 64'd0);
        in_chan  = ramp(8'hEE);
        in_sig   = sig_pat(8'hEE);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;

        // R8: configuration changed after capture
        bp_mode = 1;
        cfg_dst  = 48'hFFFFFFFFFFFF;
        cfg_src  = 48'h02000000BEEF;
        cfg_type = 16'h0800;
        send_frame(ramp(8'h21), sig_pat(8'h3C), "R8 cfg frozen");
        cfg_dst  = 48'h123456789ABC;
        cfg_src  = 48'hDEADBEEF0001;
        cfg_type = 16'hFFFF;
        send_frame(ramp(8'h77), sig_pat(8'h11), "R8 new cfg");

        // drain, then no frame without input (R1)
        while (q_data.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(m_tvalid === 1'b0, "R1", "idle with no input", 64'(m_tvalid), 64'd0);
        check(in_ready === 1'b1, "R1", "ready when idle", 64'(in_ready), 64'd1);
        finish_run();
    end
endmodule